// File: doc/BRIEF.md
# Multicycle Compute Core Sequencer

This block is a single-thread compute core that runs one kernel to its end. Its control loop has six phases and never overlaps them: fetch, decode, memory request, memory wait, execute and update. Each 16-bit instruction is read from an external program store through a request/ready handshake, addressed by an 8-bit program counter. Loads and stores go to an external byte-wide data store through a second request/ready handshake. The core holds no memory array; its only architectural state is the register file, the program counter and the three compare flags.

After reset the core sits idle until `start` is pulsed, and fetching begins at address 0. Arithmetic results are written to a 16-entry, 8-bit register file. A compare instruction records whether the signed difference of two registers is negative, zero or positive. The three conditional branches then test those flags. A return instruction raises `done` and the core fetches nothing more until the next reset.

Top module: `gpu_seq_core`

## Requirements
- R1: After reset and before `start` is pulsed, `done`, `imem_req` and `dmem_req` stay low. Registers and compare flags reset to zero, and the first fetch after `start` reads address 0.
- R2: With memories that answer in the same cycle, each instruction takes exactly six cycles. Accepted fetches are six cycles apart, and without a branch the addresses go 0, 1, 2 in order.
- R3: During a fetch, `imem_req` and `imem_addr` stay steady until `imem_ready` is high, and every cycle of program-store stall adds one cycle to the instruction.
- R4: Instruction fields: opcode in [15:12], rd in [11:8], rs in [7:4], rt in [3:0], and the 8-bit immediate or branch target in [7:0]. The opcodes are: 0 no-op, 1 CONST, 2 ADD, 3 SUB, 4 MUL, 5 DIV, 6 CMP, 7 BRN, 8 BRZ, 9 BRP, A LOAD, B STORE and F RET. CONST writes the immediate to rd.
- R5: ADD, SUB and MUL write rs op rt to rd modulo 256. DIV writes the unsigned quotient, or zero when rt is zero.
- R6: CMP sets exactly one flag, N, Z or P, from the signed 9-bit difference rs − rt. The flags keep that value through any later instructions other than CMP.
- R7: BRN, BRZ and BRP load the target into the program counter when the N, Z or P flag is set. Otherwise the program counter increments.
- R8: LOAD reads the data byte at address reg[rs] into rd. STORE writes reg[rt] to address reg[rs]. `dmem_req`, `dmem_we`, `dmem_addr` and `dmem_wdata` are held until `dmem_ready`, and no other opcode raises `dmem_req`.
- R9: Opcodes C, D and E act as no-ops. They change no register and no flag, make no data access, and the program counter increments.
- R10: RET raises `done`, and `done` stays high. After RET, `imem_req` never rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse; begins fetching at address 0 |
| imem_req | output | 1 | Program-store read request |
| imem_addr | output | 8 | Program counter being fetched |
| imem_ready | input | 1 | Instruction on `imem_data` is valid |
| imem_data | input | 16 | Instruction word |
| dmem_req | output | 1 | Data-store access request |
| dmem_we | output | 1 | 1 = write, 0 = read |
| dmem_addr | output | 8 | Data address (reg[rs]) |
| dmem_wdata | output | 8 | Store data (reg[rt]) |
| dmem_ready | input | 1 | Access accepted / read data valid |
| dmem_rdata | input | 8 | Read data |
| done | output | 1 | Kernel has returned |

## Verification
Internal state can only be seen through the two memory ports and `done`. A wrong compare flag shows up as a fetch from the wrong address on the instruction right after the branch, about six cycles after the branch was fetched. A wrong register value appears on `dmem_wdata` or `dmem_addr` at the next store that uses that register. A phase sequencer that skips or repeats a state changes the spacing between accepted fetches, and that is visible within one instruction. The kernels in the bench end in a store so that every result reaches a port.

// File: rtl/seqcore_pkg.sv
// seqcore_pkg: shared encodings for the sequenced compute core.
// Assumes a 16-bit instruction word with four 4-bit fields.
package seqcore_pkg;

    localparam int INSTR_W   = 16;
    localparam int OPC_W     = 4;
    localparam int REG_IDX_W = 4;
    localparam int IMM_W     = 8;

    typedef enum logic [OPC_W-1:0] {
        OPC_NOP   = 4'h0,
        OPC_CONST = 4'h1,
        OPC_ADD   = 4'h2,
        OPC_SUB   = 4'h3,
        OPC_MUL   = 4'h4,
        OPC_DIV   = 4'h5,
        OPC_CMP   = 4'h6,
        OPC_BRN   = 4'h7,
        OPC_BRZ   = 4'h8,
        OPC_BRP   = 4'h9,
        OPC_LOAD  = 4'hA,
        OPC_STORE = 4'hB,
        OPC_RET   = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_REQUEST,
        ST_WAIT,
        ST_EXECUTE,
        ST_UPDATE,
        ST_HALT
    } state_e;

    typedef struct packed {
        opcode_e              op;
        logic [REG_IDX_W-1:0] rd;
        logic [REG_IDX_W-1:0] rs;
        logic [REG_IDX_W-1:0] rt;
        logic [IMM_W-1:0]     imm;
        logic                 reg_we;
        logic                 mem_rd;
        logic                 mem_wr;
        logic                 is_cmp;
        logic                 is_branch;
        logic                 is_ret;
    } decoded_t;

endpackage

// File: rtl/seqcore_decode.sv
// seqcore_decode: splits an instruction word into fields and control bits.
// Purely combinational. Opcodes without a defined meaning decode as no-ops.
module seqcore_decode
    import seqcore_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output decoded_t           dec
);

    // Field extraction and per-opcode control flags.
    always_comb begin
        dec     = '0;
        dec.rd  = instr[11:8];
        dec.rs  = instr[7:4];
        dec.rt  = instr[3:0];
        dec.imm = instr[7:0];
        unique case (instr[15:12])
            4'h1: begin dec.op = OPC_CONST; dec.reg_we = 1'b1; end
            4'h2: begin dec.op = OPC_ADD;   dec.reg_we = 1'b1; end
            4'h3: begin dec.op = OPC_SUB;   dec.reg_we = 1'b1; end
            4'h4: begin dec.op = OPC_MUL;   dec.reg_we = 1'b1; end
            4'h5: begin dec.op = OPC_DIV;   dec.reg_we = 1'b1; end
            4'h6: begin dec.op = OPC_CMP;   dec.is_cmp = 1'b1; end
            4'h7: begin dec.op = OPC_BRN;   dec.is_branch = 1'b1; end
            4'h8: begin dec.op = OPC_BRZ;   dec.is_branch = 1'b1; end
            4'h9: begin dec.op = OPC_BRP;   dec.is_branch = 1'b1; end
            4'hA: begin dec.op = OPC_LOAD;  dec.reg_we = 1'b1; dec.mem_rd = 1'b1; end
            4'hB: begin dec.op = OPC_STORE; dec.mem_wr = 1'b1; end
            4'hF: begin dec.op = OPC_RET;   dec.is_ret = 1'b1; end
            default: dec.op = OPC_NOP;
        endcase
    end

endmodule

// File: rtl/seqcore_alu.sv
// seqcore_alu: integer datapath for one instruction.
// Results wrap at W bits, a zero divisor yields zero, and the compare flags
// come from a signed (W+1)-bit difference so that no overflow can occur.
module seqcore_alu
    import seqcore_pkg::*;
#(
    parameter int W = 8
) (
    input  opcode_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   imm,
    output logic [W-1:0]   result,
    output logic [2:0]     nzp
);

    logic signed [W:0] diff;

    // Result selection by opcode.
    always_comb begin
        unique case (op)
            OPC_CONST: result = imm;
            OPC_ADD:   result = a + b;
            OPC_SUB:   result = a - b;
            OPC_MUL:   result = a * b;
            OPC_DIV:   result = (b == '0) ? '0 : a / b;
            default:   result = '0;
        endcase
    end

    // Signed compare flags, N in bit 2, Z in bit 1, P in bit 0.
    always_comb begin
        diff = $signed({a[W-1], a}) - $signed({b[W-1], b});
        if (diff < 0)       nzp = 3'b100;
        else if (diff == 0) nzp = 3'b010;
        else                nzp = 3'b001;
    end

endmodule

// File: rtl/seqcore_regfile.sv
// seqcore_regfile: NREGS x W register file, two combinational read ports,
// one synchronous write port. All entries clear on reset.
module seqcore_regfile #(
    parameter int NREGS = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs_q [NREGS];

    // Storage: reset to zero, then write on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    // Read ports.
    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/gpu_seq_core.sv
// gpu_seq_core: six-phase sequenced compute core (fetch, decode, request,
// wait, execute, update). One instruction is in flight at a time. Both
// memories are external and answer through request/ready handshakes; the
// requester holds its outputs until ready is seen.
module gpu_seq_core
    import seqcore_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PC_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                imem_req,
    output logic [PC_W-1:0]     imem_addr,
    input  logic                imem_ready,
    input  logic [INSTR_W-1:0]  imem_data,
    output logic                dmem_req,
    output logic                dmem_we,
    output logic [DATA_W-1:0]   dmem_addr,
    output logic [DATA_W-1:0]   dmem_wdata,
    input  logic                dmem_ready,
    input  logic [DATA_W-1:0]   dmem_rdata,
    output logic                done
);

    localparam int NREGS = 2 ** REG_IDX_W;

    state_e               state_q;
    logic [PC_W-1:0]      pc_q;
    logic [INSTR_W-1:0]   ir_q;
    decoded_t             dec_w, dec_q;
    logic [DATA_W-1:0]    rs_val, rt_val, alu_res, result_q, rdata_q;
    logic [2:0]           alu_nzp, cmp_q, nzp_q;
    logic                 mem_op, take_branch, rf_we;
    logic [DATA_W-1:0]    rf_wdata;

    seqcore_decode i_decode (
        .instr (ir_q),
        .dec   (dec_w)
    );

    seqcore_regfile #(.NREGS(NREGS), .W(DATA_W)) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (dec_q.rd),
        .wdata   (rf_wdata),
        .raddr_a (dec_q.rs),
        .rdata_a (rs_val),
        .raddr_b (dec_q.rt),
        .rdata_b (rt_val)
    );

    seqcore_alu #(.W(DATA_W)) i_alu (
        .op     (dec_q.op),
        .a      (rs_val),
        .b      (rt_val),
        .imm    (DATA_W'(dec_q.imm)),
        .result (alu_res),
        .nzp    (alu_nzp)
    );

    // Control decisions taken from the latched decode.
    always_comb begin
        mem_op      = dec_q.mem_rd | dec_q.mem_wr;
        take_branch = ((dec_q.op == OPC_BRN) & nzp_q[2]) |
                      ((dec_q.op == OPC_BRZ) & nzp_q[1]) |
                      ((dec_q.op == OPC_BRP) & nzp_q[0]);
        rf_we       = (state_q == ST_UPDATE) & dec_q.reg_we;
        rf_wdata    = dec_q.mem_rd ? rdata_q : result_q;
    end

    // Phase sequencer and architectural state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pc_q     <= '0;
            ir_q     <= '0;
            dec_q    <= '0;
            result_q <= '0;
            rdata_q  <= '0;
            cmp_q    <= '0;
            nzp_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (start) state_q <= ST_FETCH;
                ST_FETCH:   if (imem_ready) begin
                                ir_q    <= imem_data;
                                state_q <= ST_DECODE;
                            end
                ST_DECODE:  begin
                                dec_q   <= dec_w;
                                state_q <= ST_REQUEST;
                            end
                ST_REQUEST: state_q <= ST_WAIT;
                ST_WAIT:    if (!mem_op || dmem_ready) begin
                                if (dec_q.mem_rd) rdata_q <= dmem_rdata;
                                state_q <= ST_EXECUTE;
                            end
                ST_EXECUTE: begin
                                result_q <= alu_res;
                                cmp_q    <= alu_nzp;
                                state_q  <= ST_UPDATE;
                            end
                ST_UPDATE:  begin
                                if (dec_q.is_cmp) nzp_q <= cmp_q;
                                pc_q    <= take_branch ? PC_W'(dec_q.imm) : pc_q + 1'b1;
                                state_q <= dec_q.is_ret ? ST_HALT : ST_FETCH;
                            end
                default:    state_q <= ST_HALT;
            endcase
        end
    end

    // Port drives.
    assign imem_req   = (state_q == ST_FETCH);
    assign imem_addr  = pc_q;
    assign dmem_req   = (state_q == ST_WAIT) & mem_op;
    assign dmem_we    = (state_q == ST_WAIT) & dec_q.mem_wr;
    assign dmem_addr  = rs_val;
    assign dmem_wdata = rt_val;
    assign done       = (state_q == ST_HALT);

    // R3: fetch request held steady while the program store stalls.
    a_r3_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        imem_req && !imem_ready |=> imem_req && $stable(imem_addr));

    // R8: data request and its payload held steady until accepted.
    a_r8_dmem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_req && !dmem_ready |=> dmem_req && $stable(dmem_addr)
                                 && $stable(dmem_we) && $stable(dmem_wdata));

    // R2: phases after decode follow in fixed order.
    a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DECODE |=> state_q == ST_REQUEST ##1 state_q == ST_WAIT);

    // R2: execute is always followed by update.
    a_r2_exec_update: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EXECUTE |=> state_q == ST_UPDATE);

    // R6: at most one compare flag is ever set.
    a_r6_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nzp_q));

    // R6: flags change only on the update of a compare.
    a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_UPDATE && dec_q.is_cmp) |=> $stable(nzp_q));

    // R10: once done, it stays and no memory request is raised.
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && !imem_req && !dmem_req);

endmodule

// File: tb/test_gpu_seq_core.sv
module test_gpu_seq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        imem_req, imem_ready;
    logic [7:0]  imem_addr;
    logic [15:0] imem_data;
    logic        dmem_req, dmem_we, dmem_ready, done;
    logic [7:0]  dmem_addr, dmem_wdata, dmem_rdata;

    always #4 clk = ~clk;

    gpu_seq_core i_gpu_seq_core (
        .clk, .rst_n, .start,
        .imem_req, .imem_addr, .imem_ready, .imem_data,
        .dmem_req, .dmem_we, .dmem_addr, .dmem_wdata, .dmem_ready, .dmem_rdata,
        .done
    );

    // External memory models with programmable latency.
    logic [15:0] prog [256];
    logic [7:0]  dmem [256];
    int imem_lat = 0, dmem_lat = 0, icnt = 0, dcnt = 0;

    assign imem_ready = imem_req && (icnt >= imem_lat);
    assign imem_data  = prog[imem_addr];
    assign dmem_ready = dmem_req && (dcnt >= dmem_lat);
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) begin
        icnt <= (imem_req && !imem_ready) ? icnt + 1 : 0;
        dcnt <= (dmem_req && !dmem_ready) ? dcnt + 1 : 0;
        if (dmem_req && dmem_ready && dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    // Observation: fetch log, data request cycles, handshake holding.
    int cyc = 0, fetch_n = 0, dreq_cycles = 0, hold_err = 0;
    int fetch_cyc [64];
    logic [7:0] fetch_adr [64];
    logic p_ireq = 0, p_irdy = 0, p_dreq = 0, p_drdy = 0;
    logic [7:0] p_iadr = 0, p_dadr = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (imem_req && imem_ready && fetch_n < 64) begin
            fetch_cyc[fetch_n] = cyc;
            fetch_adr[fetch_n] = imem_addr;
            fetch_n = fetch_n + 1;
        end
        if (dmem_req) dreq_cycles = dreq_cycles + 1;
        if (p_ireq && !p_irdy && (!imem_req || imem_addr != p_iadr)) hold_err = hold_err + 1;
        if (p_dreq && !p_drdy && (!dmem_req || dmem_addr != p_dadr)) hold_err = hold_err + 1;
        p_ireq = imem_req; p_irdy = imem_ready; p_iadr = imem_addr;
        p_dreq = dmem_req; p_drdy = dmem_ready; p_dadr = dmem_addr;
    end

    int n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mems();
        for (int i = 0; i < 256; i++) begin
            prog[i] = 16'h0000;
            dmem[i] = 8'h00;
        end
    endtask

    // Reset, launch, wait for done (or time out as a failure).
    task automatic run_kernel();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        fetch_n = 0; dreq_cycles = 0; hold_err = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
        check(done, "R10 kernel reached done", done, 1);
    endtask

    // Arithmetic vectors: {opcode, a, b, expected}.
    localparam logic [27:0] VECS [9] = '{
        {4'h2, 8'd10,  8'd20,  8'd30},
        {4'h2, 8'd200, 8'd100, 8'd44},
        {4'h3, 8'd5,   8'd7,   8'd254},
        {4'h3, 8'd9,   8'd9,   8'd0},
        {4'h4, 8'd16,  8'd17,  8'd16},
        {4'h4, 8'd3,   8'd5,   8'd15},
        {4'h5, 8'd100, 8'd7,   8'd14},
        {4'h5, 8'd9,   8'd0,   8'd0},
        {4'h5, 8'd255, 8'd255, 8'd1}
    };

    // Compare-and-branch kernel; result byte at 0x20 is 0 if taken, 0x11 if not.
    task automatic run_branch(input logic [7:0] a, input logic [7:0] b,
                              input logic [3:0] brop, input bit taken);
        clear_mems();
        prog[0] = {4'h1, 4'h1, a};
        prog[1] = {4'h1, 4'h2, b};
        prog[2] = 16'h6012;          // CMP R1,R2
        prog[3] = 16'h1700;          // CONST R7,0 between CMP and branch
        prog[4] = {brop, 4'h0, 8'h06};
        prog[5] = 16'h1511;          // CONST R5,0x11 (skipped when taken)
        prog[6] = 16'h1620;          // CONST R6,0x20
        prog[7] = 16'hB065;          // STORE [R6],R5
        prog[8] = 16'hF000;
        dmem[8'h20] = 8'hEE;
        run_kernel();
        check(dmem[8'h20] == (taken ? 8'h00 : 8'h11), "R6 R7 branch result",
              dmem[8'h20], taken ? 0 : 17);
        check(fetch_adr[5] == (taken ? 8'h06 : 8'h05), "R7 address after branch",
              fetch_adr[5], taken ? 6 : 5);
    endtask

    initial begin
        clear_mems();
        // R1: idle after reset without start.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(!done && !imem_req && !dmem_req, "R1 idle after reset",
              {done, imem_req, dmem_req}, 0);

        // Vector table: R4 R5 arithmetic, R2 timing, R10 no fetch past RET.
        for (int v = 0; v < 9; v++) begin
            clear_mems();
            prog[0] = {4'h1, 4'h1, VECS[v][23:16]};
            prog[1] = {4'h1, 4'h2, VECS[v][15:8]};
            prog[2] = {VECS[v][27:24], 4'h3, 4'h1, 4'h2};
            prog[3] = 16'h1410;      // CONST R4,0x10
            prog[4] = 16'hB043;      // STORE [R4],R3
            prog[5] = 16'hF000;
            dmem[8'h10] = 8'hEE;
            run_kernel();
            check(dmem[8'h10] == VECS[v][7:0], "R5 arithmetic result",
                  dmem[8'h10], VECS[v][7:0]);
            check(fetch_n == 6, "R10 no fetch after RET", fetch_n, 6);
        end
        check(fetch_adr[0] == 0 && fetch_adr[1] == 1 && fetch_adr[2] == 2,
              "R1 R2 sequential fetch from 0", fetch_adr[2], 2);
        check(fetch_cyc[1] - fetch_cyc[0] == 6, "R2 six cycles per instruction",
              fetch_cyc[1] - fetch_cyc[0], 6);

        // R10: done sticks and nothing is fetched afterwards.
        begin
            int extra = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (imem_req || !done) extra++;
            end
            check(extra == 0, "R10 done sticky, fetch stopped", extra, 0);
        end

        // R6 R7: signed compare and each branch kind.
        run_branch(8'd3,   8'd5,   4'h7, 1'b1);
        run_branch(8'd5,   8'd5,   4'h8, 1'b1);
        run_branch(8'd2,   8'hFF,  4'h9, 1'b1);
        run_branch(8'h80,  8'h01,  4'h7, 1'b1);
        run_branch(8'd3,   8'd5,   4'h8, 1'b0);
        run_branch(8'd3,   8'd5,   4'h9, 1'b0);
        run_branch(8'd5,   8'd5,   4'h7, 1'b0);

        // R3 R8: load/store with stalled memories.
        clear_mems();
        imem_lat = 2; dmem_lat = 3;
        prog[0] = 16'h1130;          // CONST R1,0x30
        prog[1] = 16'hA210;          // LOAD R2,[R1]
        prog[2] = 16'h1331;          // CONST R3,0x31
        prog[3] = 16'hB032;          // STORE [R3],R2
        prog[4] = 16'hF000;
        dmem[8'h30] = 8'h5A;
        run_kernel();
        check(dmem[8'h31] == 8'h5A, "R8 load then store", dmem[8'h31], 8'h5A);
        check(hold_err == 0, "R3 R8 requests held while stalled", hold_err, 0);
        check(fetch_cyc[1] - fetch_cyc[0] == 8, "R3 fetch stall lengthens step",
              fetch_cyc[1] - fetch_cyc[0], 8);
        check(dreq_cycles == 8, "R8 data request cycles", dreq_cycles, 8);
        imem_lat = 0; dmem_lat = 0;

        // R9: opcodes C, D, E are no-ops.
        clear_mems();
        prog[0] = 16'h1107;          // CONST R1,7
        prog[1] = 16'hC123;
        prog[2] = 16'hD100;
        prog[3] = 16'hE1FF;
        prog[4] = 16'h1440;          // CONST R4,0x40
        prog[5] = 16'hB041;          // STORE [R4],R1
        prog[6] = 16'hF000;
        run_kernel();
        check(dmem[8'h40] == 8'h07, "R9 register untouched", dmem[8'h40], 7);
        check(fetch_n == 7 && fetch_adr[4] == 8'h04, "R9 pc increments", fetch_n, 7);
        check(dreq_cycles == 1, "R9 no data access", dreq_cycles, 1);

        // R1: reset while halted clears done.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!done && !imem_req, "R1 reset clears done", done, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule